// File: doc/BRIEF.md
# Shared Cipher Data Buffer with Access Pointer

This block holds one 128-bit cipher block as four 32-bit entries. Software reaches all four through a single data address, and a small pointer picks the entry that the next data access touches. After each data write or data read the pointer steps to the following entry, and it wraps from the last entry back to the first. Software can also load the pointer directly through a second address, so it can revisit or skip entries. The same storage holds the plaintext going into the cipher engine and the result coming back.

The engine sees the whole buffer as one 128-bit word. When it finishes a block it pulses a done strobe, and all four entries load in parallel from its result bus. That load sets a completion flag, which drives an interrupt line when the interrupt enable input is high. The flag clears by itself once software has read the entries that carry output. The feedback segment size decides which entries those are: every entry for full-width blocks, the two lowest entries for 64-bit segments, and only the lowest entry for segments of 32 bits or less.

Top module: `sdb_top`

## Requirements
- R1: After synchronous reset, the pointer is 0, all entries are zero, and the completion flag and interrupt are low.
- R2: A bus write to the data address (bus_addr = 0) stores bus_wdata into the entry the pointer selects, and the pointer then advances by one, wrapping from 3 to 0.
- R3: While bus_addr = 0, bus_rdata shows the entry the pointer selects. A bus read at that address advances the pointer by one with the same wrap.
- R4: A bus write to the pointer address (bus_addr = 1) loads bus_wdata[1:0] into the pointer. While bus_addr = 1, bus_rdata returns the pointer in bits [1:0] with zeros above.
- R5: An eng_done pulse loads eng_blk_in into the four entries, with entry k taken from bits [32k+31:32k], and sets the completion flag in the same clock edge.
- R6: eng_blk_out always presents the four entries, with entry k in bits [32k+31:32k].
- R7: When eng_done and a data write occur in the same cycle, the engine load wins in every entry. The pointer still advances.
- R8: irq is high exactly when the completion flag is set and irq_en is high.
- R9: With seg_sel = 0 (128-bit) or a reserved code (5 to 7), the flag clears on the data read that completes reads of all four entries since the last load, in any order.
- R10: With seg_sel = 1 (64-bit), reads of entries 0 and 1 clear the flag. With seg_sel = 2, 3 or 4 (32, 16 or 8 bit), a read of entry 0 alone clears it. Reads of other entries leave the flag set.
- R11: Each engine load forgets the data reads made before it. Only reads after the most recent load count toward clearing the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (ignored while bus_wr is high) |
| bus_addr | input | 1 | 0 = data address, 1 = pointer address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for the current address |
| seg_sel | input | 3 | Feedback segment size code |
| irq_en | input | 1 | Interrupt enable |
| eng_done | input | 1 | Engine block-complete strobe |
| eng_blk_in | input | 128 | Result block from the engine |
| eng_blk_out | output | 128 | Buffer contents presented to the engine |
| cmp_flag | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a partly read result. In that state some entries the flag needs have been read and others have not, and it must hold while the segment size changes, the pointer is moved by hand, or a new load arrives in the middle of reads. Directed sequences reach it on purpose: they read the needed entries out of order, read entries that do not count, read before a load, and issue a load and a write in the same cycle. A long random mix of data writes, data reads, pointer loads and done pulses then runs under changing segment sizes. This keeps the buffer in partly read states with many different read masks.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

    localparam int WORD_W  = 32;
    localparam int ENTRIES = 4;
    localparam int PTR_W   = $clog2(ENTRIES);
    localparam int BLK_W   = WORD_W * ENTRIES;

    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_PTR  = 1'b1;

    typedef enum logic [2:0] {
        SEG_128 = 3'd0,
        SEG_64  = 3'd1,
        SEG_32  = 3'd2,
        SEG_16  = 3'd3,
        SEG_8   = 3'd4
    } seg_e;

    typedef logic [ENTRIES-1:0] ent_mask_t;
    typedef logic [PTR_W-1:0]   ptr_t;

    typedef struct packed {
        logic              data_wr;
        logic              data_rd;
        logic              ptr_wr;
        logic [WORD_W-1:0] wdata;
    } bus_req_t;

    // Entries that must be read before the completion flag may drop (R9, R10)
    function automatic ent_mask_t need_mask(input logic [2:0] seg);
        ent_mask_t m;
        case (seg)
            SEG_64:                m = ent_mask_t'(2'b11);
            SEG_32, SEG_16, SEG_8: m = ent_mask_t'(1'b1);
            default:               m = '1;
        endcase
        return m;
    endfunction

    function automatic ptr_t ptr_step(input ptr_t p);
        return ptr_t'(p + 1'b1);
    endfunction

    function automatic bus_req_t decode_bus(input logic wr, input logic rd,
                                            input logic addr,
                                            input logic [WORD_W-1:0] wd);
        bus_req_t r;
        r.data_wr = wr && (addr == ADDR_DATA);
        r.data_rd = rd && !wr && (addr == ADDR_DATA);
        r.ptr_wr  = wr && (addr == ADDR_PTR);
        r.wdata   = wd;
        return r;
    endfunction

endpackage

// File: rtl/sdb_ptr.sv
module sdb_ptr
    import sdb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output ptr_t     ptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (req.ptr_wr) begin
            ptr <= req.wdata[PTR_W-1:0];
        end else if (req.data_wr || req.data_rd) begin
            ptr <= ptr_step(ptr);
        end
    end

    // R2 R3
    ptr_adv_chk: assert property (@(posedge clk) disable iff (rst)
        ((req.data_wr || req.data_rd) && !req.ptr_wr) |=> ptr == ptr_t'($past(ptr) + 1'b1));

    // R4
    ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        req.ptr_wr |=> ptr == $past(req.wdata[PTR_W-1:0]));

    // R4
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(req.ptr_wr || req.data_wr || req.data_rd) |=> $stable(ptr));

endmodule

// File: rtl/sdb_store.sv
module sdb_store
    import sdb_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int N  = ENTRIES,
    localparam int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [DW*N-1:0] blk_in,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [DW-1:0]   wdata,
    output logic [DW*N-1:0] blk_out
);

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic [DW-1:0] ent_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else if (load) begin
                ent_q <= blk_in[g*DW +: DW];
            end else if (wr_en && (wr_idx == IW'(g))) begin
                ent_q <= wdata;
            end
        end
        assign blk_out[g*DW +: DW] = ent_q;
    end

    // R5 R7
    load_prio_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> blk_out == $past(blk_in));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(load || wr_en) |=> $stable(blk_out));

endmodule

// File: rtl/sdb_flag.sv
module sdb_flag
    import sdb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       rd_hit,
    input  ptr_t       rd_idx,
    input  logic [2:0] seg,
    input  logic       irq_en,
    output logic       flag,
    output logic       irq,
    output ent_mask_t  rd_mask
);

    ent_mask_t need;
    ent_mask_t mask_upd;

    always_comb begin
        need     = need_mask(seg);
        mask_upd = rd_mask | (ent_mask_t'(1) << rd_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag    <= 1'b0;
            rd_mask <= '0;
        end else if (load) begin
            flag    <= 1'b1;
            rd_mask <= '0;
        end else if (rd_hit) begin
            rd_mask <= mask_upd;
            if ((mask_upd & need) == need) begin
                flag <= 1'b0;
            end
        end
    end

    assign irq = flag && irq_en;

    // R5
    load_set_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> flag);

    // R9 R10
    clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(rd_hit));

    // R11
    mask_restart_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> rd_mask == '0);

    // R10
    no_read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !rd_hit) |=> flag);

endmodule

// File: rtl/sdb_top.sv
module sdb_top
    import sdb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic               bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    input  logic [2:0]         seg_sel,
    input  logic               irq_en,
    input  logic               eng_done,
    input  logic [BLK_W-1:0]   eng_blk_in,
    output logic [BLK_W-1:0]   eng_blk_out,
    output logic               cmp_flag,
    output logic               irq
);

    bus_req_t  req;
    ptr_t      ptr;
    ent_mask_t rd_mask;

    assign req = decode_bus(bus_wr, bus_rd, bus_addr, bus_wdata);

    sdb_ptr u_ptr (
        .clk (clk),
        .rst (rst),
        .req (req),
        .ptr (ptr)
    );

    sdb_store #(.DW(WORD_W), .N(ENTRIES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .load    (eng_done),
        .blk_in  (eng_blk_in),
        .wr_en   (req.data_wr),
        .wr_idx  (ptr),
        .wdata   (req.wdata),
        .blk_out (eng_blk_out)
    );

    sdb_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .load    (eng_done),
        .rd_hit  (req.data_rd),
        .rd_idx  (ptr),
        .seg     (seg_sel),
        .irq_en  (irq_en),
        .flag    (cmp_flag),
        .irq     (irq),
        .rd_mask (rd_mask)
    );

    // R3 R4: read data follows the address and the pointer
    always_comb begin
        if (bus_addr == ADDR_PTR) begin
            bus_rdata = WORD_W'(ptr);
        end else begin
            bus_rdata = eng_blk_out[int'(ptr)*WORD_W +: WORD_W];
        end
    end

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

endmodule

// File: tb/sdb_top_tb_top.sv
module sdb_top_tb_top;
    import sdb_pkg::*;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic         bus_addr = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [2:0]   seg_sel = 3'd0;
    logic         irq_en = 1'b0;
    logic         eng_done = 1'b0;
    logic [127:0] eng_blk_in = '0;
    logic [127:0] eng_blk_out;
    logic         cmp_flag;
    logic         irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [31:0] m_buf [4];
    logic [1:0]  m_ptr;
    logic        m_flag;
    logic [3:0]  m_mask;

    always #5 clk = ~clk;

    sdb_top dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .seg_sel(seg_sel), .irq_en(irq_en), .eng_done(eng_done),
        .eng_blk_in(eng_blk_in), .eng_blk_out(eng_blk_out),
        .cmp_flag(cmp_flag), .irq(irq)
    );

    function automatic logic [3:0] exp_need(input logic [2:0] s);
        if (s == 3'd1) return 4'b0011;
        if (s == 3'd2 || s == 3'd3 || s == 3'd4) return 4'b0001;
        return 4'b1111;
    endfunction

    function automatic logic [127:0] exp_blk();
        return {m_buf[3], m_buf[2], m_buf[1], m_buf[0]};
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag);
        chk({tag, " R6 blk_out"}, eng_blk_out, exp_blk());
        chk({tag, " R9 flag"}, 128'(cmp_flag), 128'(m_flag));
        chk({tag, " R8 irq"}, 128'(irq), 128'(m_flag && irq_en));
    endtask

    // One bus/engine cycle, starting and ending at a falling edge
    task automatic step(input string tag, input logic wr, input logic rd,
                        input logic addr, input logic [31:0] wd,
                        input logic done, input logic [127:0] bi);
        logic dw, dr, pw;
        logic [1:0] old;
        bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = wd;
        eng_done = done; eng_blk_in = bi;
        #1;
        if (addr == 1'b0) chk({tag, " R3 rdata"}, 128'(bus_rdata), 128'(m_buf[m_ptr]));
        else              chk({tag, " R4 rdata"}, 128'(bus_rdata), 128'(m_ptr));
        dw = wr && !addr;
        dr = rd && !wr && !addr;
        pw = wr && addr;
        old = m_ptr;
        if (done) begin
            for (int k = 0; k < 4; k++) m_buf[k] = bi[k*32 +: 32];
            m_mask = 4'b0;
            m_flag = 1'b1;
        end else if (dw) begin
            m_buf[old] = wd;
        end
        if (pw) m_ptr = wd[1:0];
        else if (dw || dr) m_ptr = old + 2'd1;
        if (!done && dr) begin
            m_mask = m_mask | (4'b1 << old);
            if ((m_mask & exp_need(seg_sel)) == exp_need(seg_sel)) m_flag = 1'b0;
        end
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; eng_done = 0;
        #1;
        chk_state(tag);
    endtask

    task automatic wr_data(input string t, input logic [31:0] d); step(t, 1, 0, 0, d, 0, '0); endtask
    task automatic rd_data(input string t); step(t, 0, 1, 0, '0, 0, '0); endtask
    task automatic wr_ptr(input string t, input logic [1:0] p); step(t, 1, 0, 1, 32'(p), 0, '0); endtask
    task automatic fire(input string t, input logic [127:0] b); step(t, 0, 0, 0, '0, 1, b); endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        logic [127:0] blk;
        void'($urandom(32'h5DB1_0C3A));
        for (int k = 0; k < 4; k++) m_buf[k] = '0;
        m_ptr = 0; m_flag = 0; m_mask = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk("R1 blk_out", eng_blk_out, '0);
        chk("R1 flag", 128'(cmp_flag), 0);
        chk("R1 irq", 128'(irq), 0);
        bus_addr = 1; #1;
        chk("R1 ptr", 128'(bus_rdata), 0);
        bus_addr = 0;

        // R2 five writes wrap onto entry 0
        wr_data("R2", 32'hA0A0_0001);
        wr_data("R2", 32'hB0B0_0002);
        wr_data("R2", 32'hC0C0_0003);
        wr_data("R2", 32'hD0D0_0004);
        wr_data("R2", 32'hE0E0_0005);
        chk("R2 wrap", eng_blk_out, {32'hD0D0_0004, 32'hC0C0_0003, 32'hB0B0_0002, 32'hE0E0_0005});

        // R4 pointer load then write lands in entry 2
        wr_ptr("R4", 2'd2);
        bus_addr = 1; #1; chk("R4 ptr readback", 128'(bus_rdata), 2); bus_addr = 0;
        wr_data("R4", 32'h1234_5678);
        chk("R4 entry2", 128'(eng_blk_out[95:64]), 128'(32'h1234_5678));

        // R3 reads walk and wrap
        wr_ptr("R3", 2'd3);
        rd_data("R3");
        rd_data("R3");
        bus_addr = 1; #1; chk("R3 ptr after wrap", 128'(bus_rdata), 1); bus_addr = 0;

        // R5 R8 engine load with interrupt enabled then gated
        irq_en = 1;
        blk = 128'h4444_4444_3333_3333_2222_2222_1111_1111;
        fire("R5", blk);
        chk("R5 load", eng_blk_out, blk);
        chk("R5 flag", 128'(cmp_flag), 1);
        chk("R8 irq on", 128'(irq), 1);
        irq_en = 0; #1;
        chk("R8 irq gated", 128'(irq), 0);
        irq_en = 1;

        // R9 full block needs all four reads in any order
        seg_sel = 3'd0;
        wr_ptr("R9", 2'd2);
        rd_data("R9"); rd_data("R9"); rd_data("R9");
        chk("R9 three reads keep flag", 128'(cmp_flag), 1);
        rd_data("R9");
        chk("R9 fourth read clears", 128'(cmp_flag), 0);

        // R10 64-bit segment: entries 2,3 do not count
        seg_sel = 3'd1;
        fire("R10", blk);
        wr_ptr("R10", 2'd2);
        rd_data("R10"); rd_data("R10");
        chk("R10 upper reads keep flag", 128'(cmp_flag), 1);
        wr_ptr("R10", 2'd1);
        rd_data("R10");
        chk("R10 entry1 only keeps flag", 128'(cmp_flag), 1);
        wr_ptr("R10", 2'd0);
        rd_data("R10");
        chk("R10 entries 0,1 clear", 128'(cmp_flag), 0);

        // R10 8-bit segment: entry 0 alone
        seg_sel = 3'd4;
        fire("R10", blk);
        wr_ptr("R10", 2'd0);
        rd_data("R10");
        chk("R10 entry0 clears", 128'(cmp_flag), 0);

        // R11 reads before a load do not count
        seg_sel = 3'd2;
        wr_ptr("R11", 2'd0);
        rd_data("R11");
        fire("R11", ~blk);
        chk("R11 flag set after load", 128'(cmp_flag), 1);
        rd_data("R11");
        chk("R11 entry1 does not clear", 128'(cmp_flag), 1);
        wr_ptr("R11", 2'd0);
        rd_data("R11");
        chk("R11 fresh entry0 clears", 128'(cmp_flag), 0);

        // R7 load beats a same-cycle data write; pointer still moves
        wr_ptr("R7", 2'd1);
        step("R7", 1, 0, 0, 32'hDEAD_BEEF, 1, blk);
        chk("R7 load wins", eng_blk_out, blk);
        bus_addr = 1; #1; chk("R7 ptr advanced", 128'(bus_rdata), 2); bus_addr = 0;

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            int op;
            logic [127:0] rb;
            op = int'($urandom_range(0, 99));
            if ((i % 97) == 0) seg_sel = 3'($urandom_range(0, 7));
            if ((i % 53) == 0) irq_en = 1'($urandom_range(0, 1));
            rb = {$urandom, $urandom, $urandom, $urandom};
            if (op < 30)      step("rand R2", 1, 0, 0, $urandom, 0, '0);
            else if (op < 70) step("rand R3", 0, 1, 0, '0, 0, '0);
            else if (op < 82) step("rand R4", 1, 0, 1, $urandom, 0, '0);
            else if (op < 90) step("rand R5", 0, 0, 0, '0, 1, rb);
            else if (op < 94) step("rand R7", 1, 0, 0, $urandom, 1, rb);
            else if (op < 97) step("rand R10", 0, 1, 0, '0, 1, rb);
            else              step("rand R4 read", 0, 1, 1, '0, 0, '0);
        end

        finished = 1;
        report();
    end

endmodule